// File: doc/BRIEF.md
# H-Bridge Capable PWM Controller

This block generates three complementary PWM output pairs from one shared up-counting timer. A 3-bit divider code slows the timer clock down from the block clock. The timer runs from zero up to a programmable period value and then wraps. Each pair compares the count against its own compare value. A pair drives its even output high while the count is below that value, and its odd output carries the complement.

The compare values that software writes are held in a user copy. They reach the active copy only at a 0-to-1 step of the timer, and only when the reload bit is set. In H-bridge mode the first two pairs drive the four switches of a bridge. Three qualifiers shape them: a direction bit picks which pair is live, an output gate can silence both pairs, and a high-side-off bit forces the bridge into a fixed brake pattern. A global inversion also applies in this mode.

Two external inputs act on the block. An active-low trip input can stop the generator and latch an interrupt. A falling edge on the sync input can restart the timer. Both inputs pass through the block's own synchronizers first.

Top module: `pwm_hbridge_ctrl`

## Requirements
- R1: The divider code sits in control bits 11:9. Code k makes the timer advance once every D = 2^(k+1) clock cycles, so code 0 gives 2 and code 7 gives 256. One full timer period with period value P lasts (P+1)*D cycles.
- R2: In standard mode, a pair with active compare C (with C at most P+1) holds its even output high for C*D cycles of every period. Its odd output is the complement. pwm_out bit 2i is the even output of pair i and bit 2i+1 is its odd output.
- R3: Register addresses are 0 for control, 1 for period, 2 to 4 for the compares of pairs 0 to 2, and 5 for status. A written compare becomes active only at a timer step from 0 to 1 while control bit 6 (reload) is set. While the bit is clear, the earlier active compare stays in use.
- R4: Control bits 12, 13 and 14 invert the odd outputs pwm_out[1], pwm_out[3] and pwm_out[5] respectively.
- R5: With H-bridge mode (bit 1) set, high-side-off (bit 3) clear and the output gate (bit 4) set, direction bit 2 selects the live pair. When it is set, pwm_out[1:0] carry pair 0 and pwm_out[3:2] are low. When it is clear, pwm_out[3:2] carry pair 1 and pwm_out[1:0] are low.
- R6: In H-bridge mode, high-side-off forces pwm_out[0] and pwm_out[2] high and pwm_out[1] and pwm_out[3] low, whatever the compares are.
- R7: In H-bridge mode with high-side-off clear, a clear output gate holds pwm_out[3:0] low. Outside H-bridge mode, bits 2, 3, 4 and 5 have no effect on the outputs.
- R8: In H-bridge mode, bit 5 inverts all six outputs, after the steering has been applied.
- R9: While the run bit (bit 0) is clear, all outputs are low and the timer is held at zero.
- R10: When control bit 8 is set, a falling edge on sync_n restarts the divider and the timer from zero. The restart happens on the edge after the falling edge has been seen, which is the third clock edge after sync_n goes low. When bit 8 is clear, sync_n has no effect.
- R11: When control bit 7 is set and trip_n is low after synchronization, the run bit is cleared and the interrupt flag is set. This happens on the third clock edge after trip_n falls, and the outputs go low one edge later. When bit 7 is clear, trip_n has no effect.
- R12: After reset, all registers read zero and irq and the outputs are low. The interrupt flag is read at status bit 0, and it stays set until a write to status with bit 0 equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | AW (3) | Register address for write and read |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data for reg_addr, combinational |
| trip_n | input | 1 | Active-low trip request |
| sync_n | input | 1 | Timer restart, acts on a falling edge |
| irq | output | 1 | Trip interrupt flag |
| pwm_out | output | 2*NPAIR (6) | PWM outputs, even and odd member of each pair |

## Verification
The bench builds the block with its defaults: three pairs, a 16-bit timer and 16-bit data. A period value of 9 keeps a full period short even at divide-by-256, so duty counts and edge-to-edge spacing can be measured exactly for codes 0, 2 and 7. Compare values of 0 and 0xFFFF pin each pair to a fixed level, which turns every steering, inversion and trip case into a single comparison of a static 6-bit pattern. With a divider of 2, a compare of 3 and a period of 9, the restart latency of a sync (10 edges to the next fall) is clearly apart from the free-running period (20 edges).

// File: rtl/pwm_hb_pkg.sv
package pwm_hb_pkg;

  // control word, LSB first: run, hb_mode, dir, hi_off, out_gate, inv_all,
  // reload, trip_en, sync_en, psc[2:0], inv1, inv3, inv5
  typedef struct packed {
    logic       inv5;
    logic       inv3;
    logic       inv1;
    logic [2:0] psc;
    logic       sync_en;
    logic       trip_en;
    logic       reload;
    logic       inv_all;
    logic       out_gate;
    logic       hi_off;
    logic       dir;
    logic       hb_mode;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int PSC_W    = 3;
  localparam int ADR_CTRL = 0;
  localparam int ADR_PER  = 1;
  localparam int ADR_CMP0 = 2;

endpackage

// File: rtl/pwm_hb_prescaler.sv
module pwm_hb_prescaler
  import pwm_hb_pkg::*;
#(
  parameter int CODE_W = PSC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  localparam int DIV_W = 1 << CODE_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] div_last;

  always_comb begin
    div_last = DIV_W'((32'd2 << code) - 32'd1);
    tick     = run && !clr && (div_q == div_last);
    if (!run || clr || tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/pwm_hb_timebase.sv
module pwm_hb_timebase #(
  parameter int CNT_W = 16,
  parameter int NPAIR = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        clr,
  input  logic                        tick,
  input  logic                        reload,
  input  logic [CNT_W-1:0]            period,
  input  logic [NPAIR-1:0][CNT_W-1:0] cmp_user,
  output logic [CNT_W-1:0]            cnt,
  output logic [NPAIR-1:0][CNT_W-1:0] cmp_act,
  output logic [NPAIR-1:0]            raw
);

  logic [CNT_W-1:0] cnt_d;
  logic             load;

  always_comb begin
    load = tick && reload && (cnt == '0) && (period != '0);
    if (!run || clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt >= period) ? '0 : cnt + 1'b1;
    end else begin
      cnt_d = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
    end else if (load) begin
      cmp_act <= cmp_user;
    end
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_cmp
    assign raw[g] = (cnt < cmp_act[g]);
  end

endmodule

// File: rtl/pwm_hb_steer.sv
module pwm_hb_steer
  import pwm_hb_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input  ctrl_t                  ctrl,
  input  logic [NPAIR-1:0]       raw,
  output logic [2*NPAIR-1:0]     pwm_d
);

  localparam int NOUT = 2 * NPAIR;

  logic [NPAIR-1:0] odd_inv;
  logic [NOUT-1:0]  base;

  for (genvar g = 0; g < NPAIR; g++) begin : g_inv
    if (g == 0) begin : g_p0
      assign odd_inv[g] = ctrl.inv1;
    end else if (g == 1) begin : g_p1
      assign odd_inv[g] = ctrl.inv3;
    end else if (g == 2) begin : g_p2
      assign odd_inv[g] = ctrl.inv5;
    end else begin : g_px
      assign odd_inv[g] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < NPAIR; i++) begin
      base[2*i]   = raw[i];
      base[2*i+1] = ~raw[i] ^ odd_inv[i];
    end
    pwm_d = base;
    if (ctrl.hb_mode) begin
      if (ctrl.hi_off) begin
        pwm_d[3:0] = 4'b0101;
      end else if (!ctrl.out_gate) begin
        pwm_d[3:0] = 4'b0000;
      end else if (ctrl.dir) begin
        pwm_d[3:2] = 2'b00;
      end else begin
        pwm_d[1:0] = 2'b00;
      end
      if (ctrl.inv_all) begin
        pwm_d = ~pwm_d;
      end
    end
    if (!ctrl.run) begin
      pwm_d = '0;
    end
  end

endmodule

// File: rtl/pwm_hb_regs.sv
module pwm_hb_regs
  import pwm_hb_pkg::*;
#(
  parameter int NPAIR  = 3,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [AW-1:0]               addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic                        trip_hit,
  output ctrl_t                       ctrl,
  output logic [CNT_W-1:0]            period,
  output logic [NPAIR-1:0][CNT_W-1:0] cmp_user,
  output logic                        irq
);

  localparam int ADR_STAT = ADR_CMP0 + NPAIR;

  ctrl_t                       ctrl_d;
  logic [CNT_W-1:0]            per_d;
  logic [NPAIR-1:0][CNT_W-1:0] cmp_d;
  logic                        irq_d;

  always_comb begin
    ctrl_d = ctrl;
    per_d  = period;
    cmp_d  = cmp_user;
    irq_d  = irq;
    if (wr) begin
      if (addr == AW'(ADR_CTRL)) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == AW'(ADR_PER))  per_d  = wdata[CNT_W-1:0];
      for (int i = 0; i < NPAIR; i++) begin
        if (addr == AW'(ADR_CMP0 + i)) cmp_d[i] = wdata[CNT_W-1:0];
      end
      if ((addr == AW'(ADR_STAT)) && wdata[0]) irq_d = 1'b0;
    end
    // a trip outranks a software write in the same cycle
    if (trip_hit) begin
      ctrl_d.run = 1'b0;
      irq_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      period   <= '0;
      cmp_user <= '0;
      irq      <= 1'b0;
    end else begin
      ctrl     <= ctrl_d;
      period   <= per_d;
      cmp_user <= cmp_d;
      irq      <= irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADR_CTRL)) rdata[CTRL_W-1:0] = ctrl;
    if (addr == AW'(ADR_PER))  rdata[CNT_W-1:0]  = period;
    for (int i = 0; i < NPAIR; i++) begin
      if (addr == AW'(ADR_CMP0 + i)) rdata[CNT_W-1:0] = cmp_user[i];
    end
    if (addr == AW'(ADR_STAT)) rdata[0] = irq;
  end

endmodule

// File: rtl/pwm_hbridge_ctrl.sv
module pwm_hbridge_ctrl
  import pwm_hb_pkg::*;
#(
  parameter int NPAIR  = 3,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int AW     = $clog2(NPAIR + 3)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 trip_n,
  input  logic                 sync_n,
  output logic                 irq,
  output logic [2*NPAIR-1:0]   pwm_out
);

  localparam int NOUT = 2 * NPAIR;

  logic [1:0]                  rst_pipe;
  logic                        rst_int_n;
  logic [1:0]                  trip_pipe;
  logic [2:0]                  sync_pipe;
  logic                        trip_hit;
  logic                        sync_clr;
  ctrl_t                       ctrl_q;
  logic [CNT_W-1:0]            period;
  logic [NPAIR-1:0][CNT_W-1:0] cmp_user;
  logic [NPAIR-1:0][CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0]            tcnt;
  logic [NPAIR-1:0]            raw;
  logic                        tick;
  logic [NOUT-1:0]             pwm_d;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  // input synchronizers, idle high
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      trip_pipe <= '1;
      sync_pipe <= '1;
    end else begin
      trip_pipe <= {trip_pipe[0], trip_n};
      sync_pipe <= {sync_pipe[1:0], sync_n};
    end
  end

  always_comb begin
    trip_hit = ctrl_q.trip_en && !trip_pipe[1];
    sync_clr = ctrl_q.sync_en && sync_pipe[2] && !sync_pipe[1];
  end

  pwm_hb_regs #(
    .NPAIR (NPAIR),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .AW    (AW)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .trip_hit(trip_hit),
    .ctrl    (ctrl_q),
    .period  (period),
    .cmp_user(cmp_user),
    .irq     (irq)
  );

  pwm_hb_prescaler #(
    .CODE_W(PSC_W)
  ) u_psc (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (ctrl_q.run),
    .clr  (sync_clr),
    .code (ctrl_q.psc),
    .tick (tick)
  );

  pwm_hb_timebase #(
    .CNT_W(CNT_W),
    .NPAIR(NPAIR)
  ) u_tb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (ctrl_q.run),
    .clr     (sync_clr),
    .tick    (tick),
    .reload  (ctrl_q.reload),
    .period  (period),
    .cmp_user(cmp_user),
    .cnt     (tcnt),
    .cmp_act (cmp_act),
    .raw     (raw)
  );

  pwm_hb_steer #(
    .NPAIR(NPAIR)
  ) u_steer (
    .ctrl (ctrl_q),
    .raw  (raw),
    .pwm_d(pwm_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pwm_out <= '0;
    end else begin
      pwm_out <= pwm_d;
    end
  end

endmodule

// File: rtl/pwm_hb_chk.sv
module pwm_hb_chk
  import pwm_hb_pkg::*;
#(
  parameter int NPAIR  = 3,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input logic                        clk,
  input logic                        rstn,
  input ctrl_t                       ctrl,
  input logic                        tick,
  input logic                        clr,
  input logic [CNT_W-1:0]            tcnt,
  input logic [NPAIR-1:0][CNT_W-1:0] cmp_act,
  input logic                        trip_hit,
  input logic                        irq,
  input logic                        wr,
  input logic [AW-1:0]               addr,
  input logic [DATA_W-1:0]           wdata,
  input logic [2*NPAIR-1:0]          pwm
);

  localparam int ADR_STAT = ADR_CMP0 + NPAIR;

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstn)
    tick |=> !tick);

  // R2
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rstn)
    (ctrl.run && !tick && !clr) |=> $stable(tcnt));

  // R3
  shadow_chk: assert property (@(posedge clk) disable iff (!rstn)
    !(tick && ctrl.reload && (tcnt == '0)) |=> $stable(cmp_act));

  // R5
  dir_chk: assert property (@(posedge clk) disable iff (!rstn)
    (ctrl.run && ctrl.hb_mode && !ctrl.hi_off && ctrl.out_gate && ctrl.dir && !ctrl.inv_all)
    |=> (pwm[3:2] == 2'b00));

  // R6
  hi_off_chk: assert property (@(posedge clk) disable iff (!rstn)
    (ctrl.run && ctrl.hb_mode && ctrl.hi_off && !ctrl.inv_all) |=> (pwm[3:0] == 4'b0101));

  // R9
  run_off_chk: assert property (@(posedge clk) disable iff (!rstn)
    !ctrl.run |=> (pwm == '0));

  // R10
  sync_chk: assert property (@(posedge clk) disable iff (!rstn)
    clr |=> (tcnt == '0));

  // R11
  trip_chk: assert property (@(posedge clk) disable iff (!rstn)
    trip_hit |=> (!ctrl.run && irq));

  // R12
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstn)
    $fell(irq) |-> $past(wr && (addr == AW'(ADR_STAT)) && wdata[0]));

endmodule

bind pwm_hbridge_ctrl pwm_hb_chk #(
  .NPAIR (NPAIR),
  .CNT_W (CNT_W),
  .DATA_W(DATA_W),
  .AW    (AW)
) u_chk (
  .clk     (clk),
  .rstn    (rst_int_n),
  .ctrl    (ctrl_q),
  .tick    (tick),
  .clr     (sync_clr),
  .tcnt    (tcnt),
  .cmp_act (cmp_act),
  .trip_hit(trip_hit),
  .irq     (irq),
  .wr      (reg_wr),
  .addr    (reg_addr),
  .wdata   (reg_wdata),
  .pwm     (pwm_out)
);

// File: tb/sim_pwm_hbridge_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_hbridge_ctrl;

  localparam int NPAIR  = 3;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int AW     = 3;

  localparam int B_RUN = 0, B_HB = 1, B_DIR = 2, B_HOFF = 3, B_GATE = 4, B_INVA = 5;
  localparam int B_LOAD = 6, B_TRIPEN = 7, B_SYNCEN = 8, B_PSC = 9;
  localparam int B_INV1 = 12, B_INV3 = 13, B_INV5 = 14;
  localparam int A_CTRL = 0, A_PER = 1, A_STAT = 5;
  localparam int CHI = 16'hFFFF;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [AW-1:0]     reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              trip_n;
  logic              sync_n;
  logic              irq;
  logic [2*NPAIR-1:0] pwm_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  pwm_hbridge_ctrl #(
    .NPAIR(NPAIR), .CNT_W(CNT_W), .DATA_W(DATA_W), .AW(AW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trip_n(trip_n),
    .sync_n(sync_n), .irq(irq), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = AW'(a);
    reg_wdata = DATA_W'(d);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int div_of(input int ctl);
    return 2 << ((ctl >> B_PSC) & 7);
  endfunction

  task automatic setup(input int per, input int c0, input int c1, input int c2, input int ctl);
    wr(A_CTRL, 0);
    wr(A_PER, per);
    wr(2, c0);
    wr(3, c1);
    wr(4, c2);
    wr(A_CTRL, ctl | (1 << B_LOAD) | (1 << B_RUN));
    idle(2 * (per + 1) * div_of(ctl) + 8);
  endtask

  task automatic wait_fall();
    logic prev;
    prev = pwm_out[0];
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (prev && !pwm_out[0]) break;
      prev = pwm_out[0];
    end
  endtask

  // edges until the next fall of pwm_out[0]; optional sync pulse at the start
  task automatic gap_to_fall(input bit pulse, output int k);
    logic prev;
    prev = pwm_out[0];
    k = 0;
    if (pulse) sync_n = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      k++;
      sync_n = 1'b1;
      if (prev && !pwm_out[0]) break;
      prev = pwm_out[0];
    end
  endtask

  task automatic duty(input int win, output int h0, output int h1);
    h0 = 0;
    h1 = 0;
    repeat (win) begin
      @(negedge clk);
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
    end
  endtask

  task automatic t_reset();
    int v;
    check("R12", "outputs after reset", int'(pwm_out), 0);
    check("R12", "irq after reset", int'(irq), 0);
    rd(A_CTRL, v);
    check("R12", "control after reset", v, 0);
    rd(A_PER, v);
    check("R12", "period after reset", v, 0);
  endtask

  task automatic t_standard();
    int base;
    base = (1 << B_RUN) | (1 << B_LOAD);
    setup(9, CHI, 0, CHI, 0);
    check("R2", "static pattern standard", int'(pwm_out), 6'b011001);
    wr(A_CTRL, base | (1 << B_INV1) | (1 << B_INV3) | (1 << B_INV5));
    idle(2);
    check("R4", "odd output inverts", int'(pwm_out), 6'b110011);
    wr(A_CTRL, base | (1 << B_DIR) | (1 << B_HOFF) | (1 << B_INVA));
    idle(2);
    check("R7", "bridge bits ignored in standard mode", int'(pwm_out), 6'b011001);
    wr(A_CTRL, base | (1 << B_DIR) | (1 << B_GATE) | (1 << B_INVA));
    idle(2);
    check("R7", "gate and invert ignored in standard mode", int'(pwm_out), 6'b011001);
  endtask

  task automatic t_bridge();
    int base;
    base = (1 << B_RUN) | (1 << B_LOAD) | (1 << B_HB);
    wr(A_CTRL, base | (1 << B_HOFF) | (1 << B_GATE));
    idle(2);
    check("R6", "high side off pattern", int'(pwm_out), 6'b010101);
    wr(A_CTRL, base | (1 << B_GATE) | (1 << B_DIR));
    idle(2);
    check("R5", "direction set", int'(pwm_out), 6'b010001);
    wr(A_CTRL, base | (1 << B_GATE));
    idle(2);
    check("R5", "direction clear", int'(pwm_out), 6'b011000);
    wr(A_CTRL, base | (1 << B_DIR));
    idle(2);
    check("R7", "output gate clear", int'(pwm_out), 6'b010000);
    wr(A_CTRL, base | (1 << B_GATE) | (1 << B_DIR) | (1 << B_INVA));
    idle(2);
    check("R8", "global invert in bridge mode", int'(pwm_out), 6'b101110);
    wr(A_CTRL, (1 << B_LOAD) | (1 << B_HB) | (1 << B_HOFF));
    idle(2);
    check("R9", "run clear forces low", int'(pwm_out), 0);
  endtask

  task automatic t_prescale(input int code);
    int ctl, d, t, h0, h1, k;
    ctl = code << B_PSC;
    d   = div_of(ctl);
    t   = 10 * d;
    setup(9, 3, 3, 3, ctl);
    duty(t, h0, h1);
    check("R2", $sformatf("even high cycles code %0d", code), h0, 3 * d);
    check("R2", $sformatf("odd high cycles code %0d", code), h1, t - 3 * d);
    wait_fall();
    gap_to_fall(1'b0, k);
    check("R1", $sformatf("period length code %0d", code), k, t);
  endtask

  task automatic t_reload();
    int h0, h1;
    setup(9, 3, 3, 3, 0);
    wr(A_CTRL, 1 << B_RUN);
    wr(2, 7);
    idle(45);
    duty(20, h0, h1);
    check("R3", "compare held while reload clear", h0, 6);
    wr(A_CTRL, (1 << B_RUN) | (1 << B_LOAD));
    idle(45);
    duty(20, h0, h1);
    check("R3", "compare taken with reload set", h0, 14);
  endtask

  task automatic t_sync();
    int k;
    setup(9, 3, 3, 3, 1 << B_SYNCEN);
    wait_fall();
    gap_to_fall(1'b1, k);
    check("R10", "restart latency to fall", k, 10);
    wr(A_CTRL, 1 << B_RUN);
    idle(30);
    wait_fall();
    gap_to_fall(1'b1, k);
    check("R10", "sync ignored when disabled", k, 20);
  endtask

  task automatic t_trip();
    int v;
    setup(9, CHI, 0, CHI, 1 << B_TRIPEN);
    check("R11", "running before trip", int'(pwm_out), 6'b011001);
    trip_n = 1'b0;
    idle(4);
    check("R11", "outputs low after trip", int'(pwm_out), 0);
    check("R11", "irq after trip", int'(irq), 1);
    rd(A_CTRL, v);
    check("R11", "run bit cleared by trip", v & 1, 0);
    trip_n = 1'b1;
    idle(4);
    wr(A_STAT, 0);
    check("R12", "flag kept on write of zero", int'(irq), 1);
    rd(A_STAT, v);
    check("R12", "status bit reads set", v & 1, 1);
    wr(A_STAT, 1);
    check("R12", "flag cleared by write of one", int'(irq), 0);
    wr(A_CTRL, (1 << B_RUN) | (1 << B_LOAD));
    idle(3);
    trip_n = 1'b0;
    idle(6);
    rd(A_CTRL, v);
    check("R11", "trip ignored when disabled, run kept", v & 1, 1);
    check("R11", "trip ignored when disabled, irq", int'(irq), 0);
    check("R11", "trip ignored when disabled, outputs", int'(pwm_out), 6'b011001);
    trip_n = 1'b1;
  endtask

  initial begin
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    trip_n    = 1'b1;
    sync_n    = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_standard();
    t_bridge();
    t_prescale(0);
    t_prescale(2);
    t_prescale(7);
    t_reload();
    t_sync();
    t_trip();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule